// File: doc/BRIEF.md
# Watchdog Timer with Split-Counter Test Mode

This block is a watchdog timer for a system controller. A wide up-counter advances on a crystal-derived tick. The tick can be used directly or thinned by a free-running prescaler. When a selected bit position of the counter is crossed, an interrupt flag is raised. If software does not clear that flag within a fixed number of ticks, and reset generation is enabled, the block issues a one-cycle system reset request.

Software controls everything through a single 32-bit control word. The word is written with a write strobe and is always visible on the read-data output. A debug-acknowledge input freezes counting while a debugger holds the core, unless software sets an override. A test mode splits the counter into two independent halves that run side by side. Either half overflowing raises the interrupt, so each half can be exercised in a small fraction of the full period. Test mode also bypasses the prescaler.

Everything runs in one clock domain. The prescaler produces a single-cycle enable rather than a derived clock.

Top module: `wdog_timer`

## Requirements
- R1: The control word carries these fields. Bit 10 is the divide select, bit 9 is the debug-hold override, bit 8 is test mode and bit 7 is the run enable. Bit 6 is the interrupt enable, bits 5:4 are the interval select, bit 3 is the interrupt flag, bit 2 is the reset flag, bit 1 is the reset enable and bit 0 is restart. Bits 31:11 and bit 0 always read as 0, and the other fields read back as written.
- R2: With divide select 0 and test mode 0, the counter advances on every cycle in which the tick is high. The interrupt flag sets on the step that carries the counter across a multiple of 2^TAP. TAP is selected by the interval select: 0 gives TAP0 (13), 1 gives TAP1 (16), 2 gives TAP2 (19) and 3 gives TAP3 (25).
- R3: With divide select 1 and test mode 0, the counter advances once every 2^PRE_W ticks (256 by default).
- R4: In test mode the divide select has no effect, and the counter advances on every tick.
- R5: While the debug-acknowledge input is high and the override is 0, the counter holds. With the override at 1, debug-acknowledge has no effect.
- R6: In test mode the counter runs as two independent HALF_W-bit halves with no carry between them. A half overflowing sets the interrupt flag, which occurs every 2^HALF_W steps.
- R7: While the run enable is 0, the counter is held at zero, so counting after re-enabling starts from zero.
- R8: A write with bit 0 set clears the counter in that cycle.
- R9: The interrupt output is high exactly when both the interrupt flag and the interrupt enable are 1.
- R10: When reset enable is 1, the reset request pulses for one cycle RST_DLY counted ticks (1024 by default) after the interrupt event, and the pulse sets the reset flag. There is no pulse if the interrupt flag was cleared before then.
- R11: Writing 1 to bit 3 or bit 2 clears the matching flag. Writing 0 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Crystal-derived tick enable |
| dbg_ack_i | input | 1 | Debugger acknowledge; freezes counting |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word write data |
| rd_data_o | output | 32 | Current control word image |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The control register takes a write at the clock edge that samples the strobe, so the counter takes its first step at the following edge. The interrupt flag sets at the edge of step number 2^TAP, and the interrupt output follows in the same cycle. The bench therefore counts whole edges from the write and samples at the falling edge just before and just after the expected step. The reset request rises exactly RST_DLY edges after the interrupt edge and drops one edge later, and the bench checks all three points. With the prescaler, the phase is unknown, so the bench uses a window: the interrupt must be absent 7·2^PRE_W ticks after enabling and present 8·2^PRE_W ticks after it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CW_W       = 32;
  localparam int unsigned B_DIV      = 10;
  localparam int unsigned B_OVR      = 9;
  localparam int unsigned B_TEST     = 8;
  localparam int unsigned B_RUN      = 7;
  localparam int unsigned B_IEN      = 6;
  localparam int unsigned B_IVAL     = 4;
  localparam int unsigned B_IFLAG    = 3;
  localparam int unsigned B_RFLAG    = 2;
  localparam int unsigned B_REN      = 1;
  localparam int unsigned B_RESTART  = 0;

  typedef struct packed {
    logic       div_sel;
    logic       dbg_ovr;
    logic       test_en;
    logic       run_en;
    logic       irq_en;
    logic [1:0] ival;
    logic       rst_en;
  } wdog_cfg_t;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int unsigned PRE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic wrap_o
);
  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q;
    if (tick_i) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign wrap_o = tick_i & (&pre_q);

  // R3: one divided step per full prescaler period, never two in a row
  a_r3_wrap_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> !wrap_o);
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int unsigned CNT_W  = 26,
  parameter int unsigned HALF_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             clear_i,
  input  logic             split_i,
  output logic [CNT_W-1:0] count_o,
  output logic             half_ovf_o
);
  localparam int unsigned HI_W = CNT_W - HALF_W;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HALF_W-1:0] lo;
  logic [HI_W-1:0]   hi;
  logic              carry;

  assign lo    = cnt_q[HALF_W-1:0];
  assign hi    = cnt_q[CNT_W-1:HALF_W];
  assign carry = &lo;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (step_i) begin
      cnt_d[HALF_W-1:0]     = lo + 1'b1;
      cnt_d[CNT_W-1:HALF_W] = hi + HI_W'(split_i | carry);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o    = cnt_q;
  assign half_ovf_o = step_i & ~clear_i & split_i & ((&lo) | (&hi));

  // R7, R8: a clear request leaves the counter at zero
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (count_o == '0));
  // R5: no step, no change
  a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clear_i) |=> $stable(count_o));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W   = 26,
  parameter int unsigned HALF_W  = 13,
  parameter int unsigned PRE_W   = 8,
  parameter int unsigned TAP0    = 13,
  parameter int unsigned TAP1    = 16,
  parameter int unsigned TAP2    = 19,
  parameter int unsigned TAP3    = 25,
  parameter int unsigned RST_DLY = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        dbg_ack_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        irq_o,
  output logic        rst_req_o
);
  localparam int unsigned DLY_W = $clog2(RST_DLY + 1);
  localparam logic [CNT_W-1:0] MASK0 = CNT_W'((64'd1 << TAP0) - 64'd1);
  localparam logic [CNT_W-1:0] MASK1 = CNT_W'((64'd1 << TAP1) - 64'd1);
  localparam logic [CNT_W-1:0] MASK2 = CNT_W'((64'd1 << TAP2) - 64'd1);
  localparam logic [CNT_W-1:0] MASK3 = CNT_W'((64'd1 << TAP3) - 64'd1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(RST_DLY - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  wdog_cfg_t        cfg_q, cfg_d;
  logic             iflag_q, iflag_d;
  logic             rflag_q, rflag_d;
  logic             rreq_q, rreq_d;
  logic             armed_q, armed_d;
  logic [DLY_W-1:0] dly_q, dly_d;

  logic             pre_wrap, hold, step, kick, clr, dly_tick;
  logic             tap_hit, half_ovf, timeout, fire;
  logic [CNT_W-1:0] count, mask;

  wdog_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (srst_n),
    .tick_i (tick_i),
    .wrap_o (pre_wrap)
  );

  assign hold     = dbg_ack_i & ~cfg_q.dbg_ovr;
  assign step     = cfg_q.run_en & tick_i & ~hold
                  & (cfg_q.test_en | ~cfg_q.div_sel | pre_wrap);
  assign kick     = wr_en_i & wr_data_i[B_RESTART];
  assign clr      = ~cfg_q.run_en | kick;
  assign dly_tick = cfg_q.run_en & tick_i & ~hold;

  wdog_count #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_cnt (
    .clk        (clk),
    .rst_n      (srst_n),
    .step_i     (step),
    .clear_i    (clr),
    .split_i    (cfg_q.test_en),
    .count_o    (count),
    .half_ovf_o (half_ovf)
  );

  always_comb begin
    unique case (cfg_q.ival)
      2'd0:    mask = MASK0;
      2'd1:    mask = MASK1;
      2'd2:    mask = MASK2;
      default: mask = MASK3;
    endcase
  end

  assign tap_hit = step & ~clr & ~cfg_q.test_en & ((count & mask) == mask);
  assign timeout = tap_hit | half_ovf;

  always_comb begin
    cfg_d   = cfg_q;
    iflag_d = iflag_q;
    rflag_d = rflag_q;
    armed_d = armed_q;
    dly_d   = dly_q;
    fire    = 1'b0;
    if (wr_en_i) begin
      cfg_d.div_sel = wr_data_i[B_DIV];
      cfg_d.dbg_ovr = wr_data_i[B_OVR];
      cfg_d.test_en = wr_data_i[B_TEST];
      cfg_d.run_en  = wr_data_i[B_RUN];
      cfg_d.irq_en  = wr_data_i[B_IEN];
      cfg_d.ival    = wr_data_i[B_IVAL+1:B_IVAL];
      cfg_d.rst_en  = wr_data_i[B_REN];
      if (wr_data_i[B_IFLAG]) iflag_d = 1'b0;
      if (wr_data_i[B_RFLAG]) rflag_d = 1'b0;
    end
    if (clr) begin
      armed_d = 1'b0;
      dly_d   = '0;
    end else if (timeout) begin
      armed_d = 1'b1;
      dly_d   = '0;
    end else if (armed_q && dly_tick) begin
      if (dly_q == DLY_LAST) begin
        armed_d = 1'b0;
        fire    = cfg_q.rst_en & iflag_q;
      end else begin
        dly_d = dly_q + 1'b1;
      end
    end
    if (timeout) iflag_d = 1'b1;
    if (fire)    rflag_d = 1'b1;
    rreq_d = fire;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cfg_q   <= '0;
      iflag_q <= 1'b0;
      rflag_q <= 1'b0;
      rreq_q  <= 1'b0;
      armed_q <= 1'b0;
      dly_q   <= '0;
    end else begin
      cfg_q   <= cfg_d;
      iflag_q <= iflag_d;
      rflag_q <= rflag_d;
      rreq_q  <= rreq_d;
      armed_q <= armed_d;
      dly_q   <= dly_d;
    end
  end

  assign rd_data_o = {21'b0, cfg_q.div_sel, cfg_q.dbg_ovr, cfg_q.test_en,
                      cfg_q.run_en, cfg_q.irq_en, cfg_q.ival, iflag_q,
                      rflag_q, cfg_q.rst_en, 1'b0};
  assign irq_o     = iflag_q & cfg_q.irq_en;
  assign rst_req_o = rreq_q;

  // R1: reserved and restart positions never read as 1
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_data_o[31:11] == '0) && !rd_data_o[0]);
  // R10: reset request lasts exactly one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req_o |=> !rst_req_o);
  // R10: the pulse and the reset flag arrive together
  a_r10_flag_with_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    rst_req_o |-> rflag_q);
  // R5: debug hold freezes the count
  a_r5_debug_freeze: assert property (@(posedge clk) disable iff (!srst_n)
    (hold && cfg_q.run_en && !kick) |=> $stable(count));
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b1;
  logic        dbg_ack_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o, rst_req_o;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_timer #(
    .CNT_W(12), .HALF_W(6), .PRE_W(3),
    .TAP0(3), .TAP1(5), .TAP2(7), .TAP3(11), .RST_DLY(16)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .dbg_ack_i(dbg_ack_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  function automatic logic [31:0] cw(bit dv, bit ov, bit ts, bit rn, bit ie,
                                     logic [1:0] iv, bit re);
    return {21'b0, dv, ov, ts, rn, ie, iv, 1'b0, 1'b0, re, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en_i = 1'b1; wr_data_i = d;
    @(posedge clk); @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic steps(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    dbg_ack_i = 1'b0;
    wr(32'h0000_000C);
  endtask

  task automatic t_reset_state();
    chk(rd_data_o == 0, "R1 reset word", rd_data_o, 0);
    chk(irq_o == 0, "R9 reset irq", irq_o, 0);
    chk(rst_req_o == 0, "R10 reset req", rst_req_o, 0);
  endtask

  task automatic t_basic();
    logic [31:0] w = cw(0, 0, 0, 1, 1, 2'd0, 0);
    wr(w | 32'hFFFF_F801);
    chk(rd_data_o == w, "R1 readback", rd_data_o, w);
    steps(7);
    chk(irq_o == 0, "R2 before tap", irq_o, 0);
    steps(1);
    chk(irq_o == 1, "R2 at tap", irq_o, 1);
    chk(rd_data_o == (w | 32'h8), "R1 flag bit", rd_data_o, w | 32'h8);
    idle();
    chk(rd_data_o == 0, "R11 flags cleared", rd_data_o, 0);
  endtask

  task automatic t_ival1();
    wr(cw(0, 0, 0, 1, 1, 2'd1, 0));
    steps(31);
    chk(irq_o == 0, "R2 ival1 early", irq_o, 0);
    steps(1);
    chk(irq_o == 1, "R2 ival1 at 32", irq_o, 1);
    idle();
  endtask

  task automatic t_irq_mask();
    wr(cw(0, 0, 0, 1, 0, 2'd0, 0));
    steps(8);
    chk(irq_o == 0, "R9 masked irq", irq_o, 0);
    chk(rd_data_o[3] == 1, "R9 flag set while masked", rd_data_o[3], 1);
    idle();
  endtask

  task automatic t_divide();
    wr(cw(1, 0, 0, 1, 1, 2'd0, 0));
    steps(56);
    chk(irq_o == 0, "R3 divided early", irq_o, 0);
    steps(8);
    chk(irq_o == 1, "R3 divided due", irq_o, 1);
    idle();
  endtask

  task automatic t_test_mode();
    wr(cw(1, 0, 1, 1, 1, 2'd3, 0));
    steps(8);
    chk(irq_o == 0, "R6 no tap event in test mode", irq_o, 0);
    steps(55);
    chk(irq_o == 0, "R4 half not yet full", irq_o, 0);
    steps(1);
    chk(irq_o == 1, "R6 half overflow", irq_o, 1);
    idle();
  endtask

  task automatic t_debug();
    dbg_ack_i = 1'b1;
    wr(cw(0, 0, 0, 1, 1, 2'd0, 0));
    steps(20);
    chk(irq_o == 0, "R5 held by debug", irq_o, 0);
    dbg_ack_i = 1'b0;
    steps(7);
    chk(irq_o == 0, "R5 resumed early", irq_o, 0);
    steps(1);
    chk(irq_o == 1, "R5 resumed due", irq_o, 1);
    idle();
    dbg_ack_i = 1'b1;
    wr(cw(0, 1, 0, 1, 1, 2'd0, 0));
    steps(7);
    chk(irq_o == 0, "R5 override early", irq_o, 0);
    steps(1);
    chk(irq_o == 1, "R5 override due", irq_o, 1);
    idle();
  endtask

  task automatic t_disable();
    logic [31:0] w = cw(0, 0, 0, 1, 1, 2'd0, 0);
    wr(w);
    steps(6);
    wr(cw(0, 0, 0, 0, 1, 2'd0, 0));
    wr(w);
    steps(7);
    chk(irq_o == 0, "R7 count restarted from zero", irq_o, 0);
    steps(1);
    chk(irq_o == 1, "R7 due after re-enable", irq_o, 1);
    idle();
  endtask

  task automatic t_restart();
    logic [31:0] w = cw(0, 0, 0, 1, 1, 2'd0, 0);
    wr(w);
    steps(6);
    wr(w | 32'h1);
    chk(rd_data_o == w, "R1 restart reads 0", rd_data_o, w);
    steps(7);
    chk(irq_o == 0, "R8 restart early", irq_o, 0);
    steps(1);
    chk(irq_o == 1, "R8 restart due", irq_o, 1);
    idle();
  endtask

  task automatic t_reset_pulse();
    logic [31:0] w = cw(0, 0, 0, 1, 1, 2'd1, 1);
    wr(w);
    steps(32);
    chk(irq_o == 1, "R10 interrupt event", irq_o, 1);
    steps(15);
    chk(rst_req_o == 0, "R10 before delay", rst_req_o, 0);
    steps(1);
    chk(rst_req_o == 1, "R10 pulse", rst_req_o, 1);
    chk(rd_data_o[2] == 1, "R10 reset flag", rd_data_o[2], 1);
    steps(1);
    chk(rst_req_o == 0, "R10 pulse ends", rst_req_o, 0);
    wr(w | 32'h8);
    chk(rd_data_o[3:2] == 2'b01, "R11 clear irq only", rd_data_o[3:2], 2'b01);
    wr(w | 32'h4);
    chk(rd_data_o[3:2] == 2'b00, "R11 clear reset flag", rd_data_o[3:2], 2'b00);
    idle();
  endtask

  task automatic t_reset_avoided();
    logic [31:0] w = cw(0, 0, 0, 1, 1, 2'd1, 1);
    bit seen = 1'b0;
    wr(w);
    steps(32);
    wr(w | 32'h8);
    for (int i = 0; i < 24; i++) begin
      steps(1);
      if (rst_req_o) seen = 1'b1;
    end
    chk(seen == 0, "R10 no pulse after clear", seen, 0);
    chk(rd_data_o[2] == 0, "R10 reset flag stays 0", rd_data_o[2], 0);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    steps(4);
    t_reset_state();
    t_basic();
    t_ival1();
    t_irq_mask();
    t_divide();
    t_test_mode();
    t_debug();
    t_disable();
    t_restart();
    t_reset_pulse();
    t_reset_avoided();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule